// File: doc/BRIEF.md
# Multiplexed CAN Controller Bus Glue

This block sits between a signal processor with separate address and data buses and a CAN controller that has an Intel-style multiplexed address/data bus. It watches the processor's accesses inside one external memory window. From them it derives the controller's active-low chip select, its address latch enable, and its read and write strobes.

Chip select and address-latch mode are not decoded per access. Each is a sticky flag that the processor sets or clears by touching its own control address, with a key nibble on the data lines for the writes. A fifth decoded address is the data port. When the processor writes there in address-latch mode, the write produces an ALE pulse that latches a register address into the controller. In normal mode, a write there is a plain register write, and a read there returns register data. All controller traffic uses processor data lines 23..16, because the low half of the data bus is unused in this window.

A controller read strobe that follows the processor strobe with no added delay has a low time of about 62.5 ns when the processor inserts two wait states at 40 MHz. This meets the controller's 50 ns minimum.

Top module: `can_mux_glue`

## Requirements
- R1: After reset, chip select is released (`can_cs_n` high), address-latch mode is off, `can_ale` is low, and `can_rd_n` and `can_wr_n` are high.
- R2: While `dsp_ms_n` is high, no access changes either flag, and all controller strobes stay idle.
- R3: A read with function code 1 (`dsp_addr[11:8]`) pulls `can_cs_n` low in the same cycle the read strobe falls. Chip select then stays asserted after the read ends.
- R4: A write with function code 2 releases chip select only when `dsp_wdata[19:16]` equals 4'b1000. Any other key leaves chip select unchanged.
- R5: A write with function code 5 enters address-latch mode only when `dsp_wdata[19:16]` equals 4'b0111. Any other key leaves the mode unchanged.
- R6: In address-latch mode, a write to the data port (function code 9) holds `can_wr_n` high and drives `can_ale` as the inverse of `dsp_wr_n`.
- R7: A read with function code 6 leaves address-latch mode. After that, a data-port write holds `can_ale` low and drives `can_wr_n` equal to `dsp_wr_n`.
- R8: `can_ad_oe` is high only during a data-port write, and `can_ad_out` carries `dsp_wdata[23:16]`.
- R9: A data-port read pulls `can_rd_n` low for as long as `dsp_rd_n` is low, but only while chip select is asserted. In that case `dsp_rdata[23:16]` is `can_ad_in` and every other bit is zero. Without chip select, `can_rd_n` stays high and `dsp_rdata` is zero.
- R10: Accesses with any other function code (0, 3, 4, 7, 8, 10 to 15) leave both flags unchanged and assert no controller strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples processor strobes for flag updates |
| rst_n | input | 1 | Asynchronous active-low reset |
| dsp_ms_n | input | 1 | Active-low memory select for the controller window |
| dsp_addr | input | 12 | Low processor address bits; bits 11..8 hold the function code |
| dsp_rd_n | input | 1 | Processor read strobe, active low |
| dsp_wr_n | input | 1 | Processor write strobe, active low |
| dsp_wdata | input | 32 | Processor write data |
| dsp_rdata | output | 32 | Read data returned to the processor |
| dsp_rdata_oe | output | 1 | High when `dsp_rdata` should drive the processor bus |
| can_cs_n | output | 1 | Controller chip select, active low |
| can_ale | output | 1 | Controller address latch enable |
| can_rd_n | output | 1 | Controller read strobe, active low |
| can_wr_n | output | 1 | Controller write strobe, active low |
| can_ad_out | output | 8 | Value driven onto the multiplexed AD bus |
| can_ad_oe | output | 1 | Drive enable for the AD bus |
| can_ad_in | input | 8 | Value read from the AD bus |

## Verification
The bench places the block in each of the four combinations of chip select and address-latch mode. From each one, it applies every function code as a read, and as a write with every possible key nibble. This separates the two real keys from their fifteen near misses, and the four control codes from the eleven undefined ones. The same sweep is repeated with the window deselected, to show that such accesses have no effect. After every access, a data-port write probe and a data-port read probe recover both flags through the controller strobes. These probes also compare the bus data lanes against varying bytes.

// File: rtl/can_mux_glue.sv
module can_mux_glue #(
  parameter int DW        = 32,
  parameter int AW        = 12,
  parameter int AD_W      = 8,
  parameter int LANE_LSB  = 16,
  parameter int FN_LSB    = 8,
  parameter int FN_W      = 4,
  parameter int KEY_W     = 4,
  parameter logic [3:0] FN_CS_ON   = 4'h1,
  parameter logic [3:0] FN_CS_OFF  = 4'h2,
  parameter logic [3:0] FN_ALE_ON  = 4'h5,
  parameter logic [3:0] FN_ALE_OFF = 4'h6,
  parameter logic [3:0] FN_PORT    = 4'h9,
  parameter logic [3:0] KEY_CS_OFF = 4'h8,
  parameter logic [3:0] KEY_ALE_ON = 4'h7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dsp_ms_n,
  input  logic [AW-1:0]   dsp_addr,
  input  logic            dsp_rd_n,
  input  logic            dsp_wr_n,
  input  logic [DW-1:0]   dsp_wdata,
  output logic [DW-1:0]   dsp_rdata,
  output logic            dsp_rdata_oe,
  output logic            can_cs_n,
  output logic            can_ale,
  output logic            can_rd_n,
  output logic            can_wr_n,
  output logic [AD_W-1:0] can_ad_out,
  output logic            can_ad_oe,
  input  logic [AD_W-1:0] can_ad_in
);

  logic [FN_W-1:0]  fn;
  logic [KEY_W-1:0] key;
  logic win, rd, wr, port;
  logic hit_cs_on, hit_cs_off, hit_ale_on, hit_ale_off;
  logic cs_on, ale_mode;

  assign fn   = dsp_addr[FN_LSB +: FN_W];
  assign key  = dsp_wdata[LANE_LSB +: KEY_W];
  assign win  = !dsp_ms_n;
  assign rd   = win && !dsp_rd_n;
  assign wr   = win && !dsp_wr_n;
  assign port = win && (fn == FN_PORT);

  assign hit_cs_on   = rd && (fn == FN_CS_ON);
  assign hit_cs_off  = wr && (fn == FN_CS_OFF)  && (key == KEY_CS_OFF);
  assign hit_ale_on  = wr && (fn == FN_ALE_ON)  && (key == KEY_ALE_ON);
  assign hit_ale_off = rd && (fn == FN_ALE_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_on    <= 1'b0;
      ale_mode <= 1'b0;
    end else begin
      if (hit_cs_on)       cs_on <= 1'b1;
      else if (hit_cs_off) cs_on <= 1'b0;
      if (hit_ale_on)       ale_mode <= 1'b1;
      else if (hit_ale_off) ale_mode <= 1'b0;
    end
  end

  assign can_cs_n     = !(cs_on || hit_cs_on);
  assign can_ale      = ale_mode && port && !dsp_wr_n;
  assign can_wr_n     = !(!ale_mode && port && !dsp_wr_n);
  assign can_rd_n     = !(cs_on && port && !dsp_rd_n);
  assign can_ad_oe    = port && !dsp_wr_n;
  assign can_ad_out   = dsp_wdata[LANE_LSB +: AD_W];
  assign dsp_rdata_oe = !can_rd_n;
  assign dsp_rdata    = dsp_rdata_oe ? (DW'(can_ad_in) << LANE_LSB) : '0;

  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (can_cs_n || !dsp_rd_n) && !can_ale);

  a_r2_window_gate: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_ms_n |=> $stable(cs_on) && $stable(ale_mode));

  a_r4_release_keyed: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_on) |-> $past(!dsp_ms_n && !dsp_wr_n &&
                           dsp_addr[FN_LSB +: FN_W] == FN_CS_OFF &&
                           dsp_wdata[LANE_LSB +: KEY_W] == KEY_CS_OFF));

  a_r6_ale_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    can_ale |-> can_wr_n);

  a_r8_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    can_ad_oe |-> (!dsp_wr_n && !dsp_ms_n));

  a_r9_read_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !can_rd_n |-> !can_cs_n);

endmodule

// File: tb/sim_can_mux_glue.sv
module sim_can_mux_glue;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dsp_ms_n = 1'b1;
  logic [11:0] dsp_addr = '0;
  logic        dsp_rd_n = 1'b1;
  logic        dsp_wr_n = 1'b1;
  logic [31:0] dsp_wdata = '0;
  logic [31:0] dsp_rdata;
  logic        dsp_rdata_oe;
  logic        can_cs_n, can_ale, can_rd_n, can_wr_n, can_ad_oe;
  logic [7:0]  can_ad_out;
  logic [7:0]  can_ad_in = '0;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  can_mux_glue u0 (
    .clk(clk), .rst_n(rst_n), .dsp_ms_n(dsp_ms_n), .dsp_addr(dsp_addr),
    .dsp_rd_n(dsp_rd_n), .dsp_wr_n(dsp_wr_n), .dsp_wdata(dsp_wdata),
    .dsp_rdata(dsp_rdata), .dsp_rdata_oe(dsp_rdata_oe), .can_cs_n(can_cs_n),
    .can_ale(can_ale), .can_rd_n(can_rd_n), .can_wr_n(can_wr_n),
    .can_ad_out(can_ad_out), .can_ad_oe(can_ad_oe), .can_ad_in(can_ad_in)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic begin_acc(input bit inwin, input bit is_wr, input logic [3:0] fn, input logic [7:0] byte_v);
    @(negedge clk);
    dsp_ms_n  = !inwin;
    dsp_addr  = {fn, 8'h00};
    dsp_wdata = {8'h00, byte_v, 16'h0000};
    if (is_wr) dsp_wr_n = 1'b0; else dsp_rd_n = 1'b0;
    #1;
  endtask

  task automatic end_acc();
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    dsp_rd_n = 1'b1;
    dsp_wr_n = 1'b1;
    dsp_ms_n = 1'b1;
    #1;
  endtask

  task automatic access(input bit inwin, input bit is_wr, input logic [3:0] fn, input logic [7:0] byte_v);
    begin_acc(inwin, is_wr, fn, byte_v);
    end_acc();
  endtask

  task automatic set_state(input bit cs, input bit ale);
    access(1, 1, 4'h2, 8'h08);
    access(1, 0, 4'h6, 8'h00);
    if (cs)  access(1, 0, 4'h1, 8'h00);
    if (ale) access(1, 1, 4'h5, 8'h07);
  endtask

  task automatic probe(input bit exp_cs, input bit exp_ale, input logic [7:0] b, input string req);
    chk(can_cs_n === !exp_cs, req, 32'(can_cs_n), 32'(!exp_cs));
    begin_acc(1, 1, 4'h9, b);
    chk(can_ale === exp_ale, req, 32'(can_ale), 32'(exp_ale));
    chk(can_wr_n === exp_ale, req, 32'(can_wr_n), 32'(exp_ale));
    chk(can_ad_oe === 1'b1 && can_ad_out === b, {req, " R8"}, {23'd0, can_ad_oe, can_ad_out}, {23'd0, 1'b1, b});
    end_acc();
    chk(can_ad_oe === 1'b0 && can_ale === 1'b0 && can_wr_n === 1'b1, "R8 idle",
        {29'd0, can_ad_oe, can_ale, can_wr_n}, 32'h1);
    can_ad_in = ~b;
    begin_acc(1, 0, 4'h9, 8'h00);
    chk(can_rd_n === !exp_cs, "R9 strobe", 32'(can_rd_n), 32'(!exp_cs));
    chk(dsp_rdata === (exp_cs ? {8'h00, ~b, 16'h0000} : 32'h0), "R9 data",
        dsp_rdata, exp_cs ? {8'h00, ~b, 16'h0000} : 32'h0);
    chk(can_ad_oe === 1'b0, "R8 no drive on read", 32'(can_ad_oe), 32'h0);
    end_acc();
    chk(can_rd_n === 1'b1, "R9 release", 32'(can_rd_n), 32'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(can_cs_n === 1'b1 && can_ale === 1'b0 && can_rd_n === 1'b1 && can_wr_n === 1'b1,
        "R1 reset outputs", {28'd0, can_cs_n, can_ale, can_rd_n, can_wr_n}, 32'hB);
    @(negedge clk);
    rst_n = 1'b1;
    probe(0, 0, 8'h3C, "R1 reset flags");

    for (int st = 0; st < 4; st++) begin
      for (int fn = 0; fn < 16; fn++) begin
        for (int op = 0; op < 2; op++) begin
          for (int nib = 0; nib < (op ? 16 : 1); nib++) begin
            for (int w = 0; w < 2; w++) begin
              bit cs0, ale0, ecs, eale, inwin;
              string req;
              inwin = (w == 0);
              cs0 = st[0];
              ale0 = st[1];
              set_state(cs0, ale0);
              ecs = cs0;
              eale = ale0;
              if (inwin) begin
                if (op == 0 && fn == 1) ecs = 1;
                if (op == 1 && fn == 2 && nib == 8) ecs = 0;
                if (op == 1 && fn == 5 && nib == 7) eale = 1;
                if (op == 0 && fn == 6) eale = 0;
              end
              if (!inwin) req = "R2";
              else if (fn == 1) req = "R3";
              else if (fn == 2) req = "R4";
              else if (fn == 5) req = "R5";
              else if (fn == 6) req = "R7";
              else if (fn == 9) req = "R6";
              else req = "R10";
              begin_acc(inwin, op[0], 4'(fn), {4'h5, 4'(nib)});
              if (inwin && op == 0 && fn == 1)
                chk(can_cs_n === 1'b0, "R3 immediate select", 32'(can_cs_n), 32'h0);
              else
                chk(can_cs_n === !cs0, req, 32'(can_cs_n), 32'(!cs0));
              if (!inwin || fn != 9)
                chk(can_rd_n === 1'b1 && can_wr_n === 1'b1 && can_ale === 1'b0 && can_ad_oe === 1'b0,
                    {req, " no strobe"}, {28'd0, can_rd_n, can_wr_n, can_ale, can_ad_oe}, 32'hC);
              end_acc();
              probe(ecs, eale, 8'((fn * 16 + nib + st * 37) ^ 8'hA5), req);
            end
          end
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule